// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table in memory. It accepts one translation at a time. Each request carries the access kind (read, write or execute) and the privilege mode. A global enable and a table base address are sampled together with each request. When the enable is low, the address passes through unchanged and memory is not touched. When it is high, the walker fetches the first-level entry, then the second-level (leaf) entry, and checks presence, user privilege and the access permission. The first time a leaf is used, the walker sets its accessed flag by a compare-and-swap.

The memory side is a single request port with one request in flight. A request is either a 32-bit load or a compare-and-swap. Each request is held until the memory acknowledges it. The result comes back as a one-cycle response: either a physical address, or a fault with a two-bit cause and the faulting virtual address.

Top module: `pt_walker`

## Requirements
- R1: With the enable low at acceptance, the response follows one cycle after acceptance, the physical address equals the virtual address, no fault is flagged and no memory request is made.
- R2: The first memory access of an enabled walk is a load from table base + VA[31:22]*4.
- R3: The second access loads the leaf from (first-level entry with bits 11:0 cleared) + VA[21:12]*4.
- R4: A clear present bit (bit 0) in either entry ends the walk with a fault of cause 0, and the faulting virtual address is reported. Cause codes are 0 page fault, 1 privilege fault and 2 permission fault.
- R5: In user mode, a present leaf with its user bit (bit 4) clear faults with cause 1. In supervisor mode the user bit has no effect.
- R6: Access kind 0 needs leaf bit 1, kind 1 needs bit 2 and kind 2 needs bit 3. Kind 3 always faults. A missing permission gives cause 2. Presence is checked first, then privilege, then permission.
- R7: A leaf that passes all checks with its accessed bit (bit 5) clear triggers a compare-and-swap at the leaf address. The compare value is the leaf as fetched and the new value is the leaf with bit 5 set. A leaf whose accessed bit is already set causes no third access.
- R8: A compare-and-swap that does not match leaves the translation unaffected: the walk completes with the normal physical address.
- R9: A successful translation returns leaf[31:12] joined with VA[11:0].
- R10: A memory request and its address stay stable until acknowledged. Requests are accepted only while idle. The response is a single-cycle pulse, due 1 + n*(L+1) + c cycles after acceptance, where n is the number of memory accesses, L the acknowledge wait, and c is 1 when the leaf was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled on acceptance |
| pt_base | input | 32 | First-level table base, sampled on acceptance |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | Fault cause code |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault_va | output | 32 | Faulting virtual address (zero on success) |
| mem_req | output | 1 | Memory request pending |
| mem_cas | output | 1 | Request is a compare-and-swap |
| mem_addr | output | 32 | Memory word address |
| mem_cmp | output | 32 | Compare value for compare-and-swap |
| mem_wdata | output | 32 | Swap value for compare-and-swap |
| mem_ack | input | 1 | Memory acknowledge, rdata valid with it |
| mem_rdata | input | 32 | Load data |

## Verification
A bypassed translation must respond exactly one cycle after acceptance. An enabled walk must respond after one cycle per state, plus L+1 cycles for each memory access, plus one check cycle once the leaf is fetched. The bench predicts this count from its own table model before each request. It then compares the response strobe on every falling edge up to that cycle, so an early, late or doubled response is caught. It also records the memory addresses in order and compares them with the predicted walk. The runs use acknowledge waits of both 0 and 2.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xlat_en,
  input  logic [2*IDX_W+OFF_W-1:0] pt_base,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_va,
  input  logic [1:0]               req_acc,
  input  logic                     req_user,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [1:0]               rsp_cause,
  output logic [2*IDX_W+OFF_W-1:0] rsp_pa,
  output logic [2*IDX_W+OFF_W-1:0] rsp_fault_va,
  output logic                     mem_req,
  output logic                     mem_cas,
  output logic [2*IDX_W+OFF_W-1:0] mem_addr,
  output logic [2*IDX_W+OFF_W-1:0] mem_cmp,
  output logic [2*IDX_W+OFF_W-1:0] mem_wdata,
  input  logic                     mem_ack,
  input  logic [2*IDX_W+OFF_W-1:0] mem_rdata
);
  localparam int VA_W  = 2*IDX_W + OFF_W;
  localparam int PG_W  = VA_W - OFF_W;
  localparam int PAD_W = VA_W - IDX_W - 2;
  localparam int B_P = 0, B_R = 1, B_W = 2, B_X = 3, B_U = 4, B_A = 5;
  localparam logic [1:0] C_PAGE = 2'd0, C_PRIV = 2'd1, C_PERM = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_CHK, S_CAS, S_DONE, S_FLT} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q, base_q, leaf_q;
  logic [PG_W-1:0]  tbl_q;
  logic [1:0]       acc_q, cause_q;
  logic             usr_q, en_q, perm_ok;
  logic [VA_W-1:0]  l1_addr, l2_addr;

  assign l1_addr = base_q + {{PAD_W{1'b0}}, va_q[VA_W-1 -: IDX_W], 2'b00};
  assign l2_addr = {tbl_q, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, va_q[OFF_W +: IDX_W], 2'b00};

  always_comb begin
    case (acc_q)
      2'd0:    perm_ok = leaf_q[B_R];
      2'd1:    perm_ok = leaf_q[B_W];
      2'd2:    perm_ok = leaf_q[B_X];
      default: perm_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      leaf_q  <= '0;
      tbl_q   <= '0;
      acc_q   <= '0;
      cause_q <= C_PAGE;
      usr_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= pt_base;
          acc_q  <= req_acc;
          usr_q  <= req_user;
          en_q   <= xlat_en;
          st     <= xlat_en ? S_L1 : S_DONE;
        end
        S_L1: if (mem_ack) begin
          if (!mem_rdata[B_P]) begin
            cause_q <= C_PAGE;
            st      <= S_FLT;
          end else begin
            tbl_q <= mem_rdata[VA_W-1:OFF_W];
            st    <= S_L2;
          end
        end
        S_L2: if (mem_ack) begin
          leaf_q <= mem_rdata;
          st     <= S_CHK;
        end
        S_CHK: begin
          if (!leaf_q[B_P]) begin
            cause_q <= C_PAGE;
            st      <= S_FLT;
          end else if (usr_q && !leaf_q[B_U]) begin
            cause_q <= C_PRIV;
            st      <= S_FLT;
          end else if (!perm_ok) begin
            cause_q <= C_PERM;
            st      <= S_FLT;
          end else if (!leaf_q[B_A]) begin
            st <= S_CAS;
          end else begin
            st <= S_DONE;
          end
        end
        S_CAS:  if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign rsp_valid    = (st == S_DONE) || (st == S_FLT);
  assign rsp_fault    = (st == S_FLT);
  assign rsp_cause    = (st == S_FLT) ? cause_q : C_PAGE;
  assign rsp_pa       = (st != S_DONE) ? '0 :
                        en_q ? {leaf_q[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : va_q;
  assign rsp_fault_va = (st == S_FLT) ? va_q : '0;

  assign mem_req   = (st == S_L1) || (st == S_L2) || (st == S_CAS);
  assign mem_cas   = (st == S_CAS);
  assign mem_addr  = (st == S_L1) ? l1_addr : l2_addr;
  assign mem_cmp   = leaf_q;
  assign mem_wdata = leaf_q | (VA_W'(1) << B_A);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_cas));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlat_en |=> rsp_valid && !rsp_fault && !mem_req && rsp_pa == $past(req_va));

  // R7
  cas_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cas |-> mem_cmp[B_P] && !mem_cmp[B_A] && mem_addr == $past(mem_addr));

  // R4
  l1_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_L1) && mem_ack && !mem_rdata[B_P] |=> rsp_fault && rsp_cause == C_PAGE && rsp_fault_va == $past(va_q));

  // R6
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK) && leaf_q[B_P] && (!usr_q || leaf_q[B_U]) && acc_q == 2'd3 |=> rsp_fault && rsp_cause == C_PERM);

  // R9
  pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        xlat_en = 1'b0, req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] pt_base = '0, req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req, mem_cas;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_pa, rsp_fault_va, mem_addr, mem_cmp, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_run = 0, n_fail = 0;
  int lat_cfg = 0, wcnt = 0;
  bit interfere = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] got_addr [$];

  always #(PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_acc(req_acc), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_pa(rsp_pa),
    .rsp_fault_va(rsp_fault_va), .mem_req(mem_req), .mem_cas(mem_cas),
    .mem_addr(mem_addr), .mem_cmp(mem_cmp), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == lat_cfg) begin
        wcnt = 0;
        mem_ack = 1'b1;
        got_addr.push_back(mem_addr);
        if (mem_cas) begin
          if (interfere) mem[mem_addr] = rd(mem_addr) ^ 32'h100;
          mem_rdata = rd(mem_addr);
          if (mem_rdata == mem_cmp) mem[mem_addr] = mem_wdata;
        end else begin
          mem_rdata = rd(mem_addr);
        end
      end else begin
        wcnt++;
        mem_ack = 1'b0;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic xlate(input bit en, input logic [31:0] va, input logic [1:0] acc, input bit usr);
    logic [31:0] e1, e2, a1, a2, exp_pa, exp_leaf_after;
    logic [31:0] exp_addr [3];
    bit          ef, leaf, cas;
    logic [1:0]  ec;
    int          t, lat;
    ef = 0; ec = 0; leaf = 0; cas = 0; t = 0; exp_pa = va;
    a2 = 32'h0; e2 = 32'h0; exp_leaf_after = 32'h0;
    if (en) begin
      a1 = pt_base + {20'h0, va[31:22], 2'b00};
      e1 = rd(a1);
      exp_addr[0] = a1; t = 1;
      if (!e1[0]) begin
        ef = 1; ec = 0;
      end else begin
        a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        e2 = rd(a2);
        exp_addr[1] = a2; t = 2; leaf = 1;
        if (!e2[0]) begin ef = 1; ec = 0; end
        else if (usr && !e2[4]) begin ef = 1; ec = 1; end
        else if (!((acc == 0 && e2[1]) || (acc == 1 && e2[2]) || (acc == 2 && e2[3]))) begin ef = 1; ec = 2; end
        else begin
          exp_pa = {e2[31:12], va[11:0]};
          if (!e2[5]) begin
            cas = 1; t = 3; exp_addr[2] = a2;
            exp_leaf_after = interfere ? (e2 ^ 32'h100) : (e2 | 32'h20);
          end
        end
      end
    end
    lat = 1 + t * (lat_cfg + 1) + (leaf ? 1 : 0);
    got_addr.delete();

    @(negedge clk);
    xlat_en = en; req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= lat; n++) begin
      // R10 response strobe compared every cycle against predicted due cycle
      chk(rsp_valid == (n == lat), "R10 rsp_valid timing", 32'(rsp_valid), 32'(n == lat));
      if (!en) chk(!mem_req, "R1 no memory access when bypassed", 32'(mem_req), 32'h0);
      if (n < lat) @(negedge clk);
    end
    chk(rsp_fault == ef, ef ? "R4 fault flag" : "R9 fault flag", 32'(rsp_fault), 32'(ef));
    if (ef) begin
      chk(rsp_cause == ec, ec == 0 ? "R4 cause" : (ec == 1 ? "R5 cause" : "R6 cause"), 32'(rsp_cause), 32'(ec));
      chk(rsp_fault_va == va, "R4 fault va", rsp_fault_va, va);
    end else begin
      chk(rsp_pa == exp_pa, en ? "R9 physical address" : "R1 identity address", rsp_pa, exp_pa);
    end
    chk(got_addr.size() == t, "R7 memory access count", 32'(got_addr.size()), 32'(t));
    if (got_addr.size() == t) begin
      if (t >= 1) chk(got_addr[0] == exp_addr[0], "R2 first-level address", got_addr[0], exp_addr[0]);
      if (t >= 2) chk(got_addr[1] == exp_addr[1], "R3 leaf address", got_addr[1], exp_addr[1]);
      if (t >= 3) chk(got_addr[2] == exp_addr[2], "R7 swap address", got_addr[2], exp_addr[2]);
    end
    if (cas) chk(rd(a2) == exp_leaf_after, interfere ? "R8 leaf after failed swap" : "R7 leaf after swap", rd(a2), exp_leaf_after);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 single pulse then idle", {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    pt_base = 32'h0001_0000;
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_0004] = 32'h0050_0017;
    mem[32'h0002_0008] = 32'h0060_002B;
    mem[32'h0002_0010] = 32'h0070_0007;
    mem[32'h0002_0014] = 32'h0080_0003;
    mem[32'h0003_0000] = 32'h0004_0001;
    mem[32'h0004_0000] = 32'h0090_003F;

    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req && !rsp_fault, "R10 reset outputs quiet", {29'h0, rsp_valid, mem_req, rsp_fault}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", 32'(req_ready), 32'h1);

    xlate(0, 32'hDEAD_BEEF, 2'd1, 1);      // R1
    xlate(1, 32'h0040_1234, 2'd0, 1);      // R7 swap on first use, R9
    xlate(1, 32'h0040_1ABC, 2'd1, 1);      // R7 no swap once accessed
    xlate(1, 32'h0040_1000, 2'd2, 1);      // R6 execute missing
    xlate(1, 32'h0080_2ABC, 2'd0, 0);      // R4 first level absent
    xlate(1, 32'h0040_2010, 2'd0, 1);      // R5 user without user bit
    xlate(1, 32'h0040_2010, 2'd0, 0);      // R5 supervisor ignores user bit
    xlate(1, 32'h0040_2FF0, 2'd2, 0);      // R6 execute allowed
    xlate(1, 32'h0040_2004, 2'd1, 0);      // R6 write missing
    xlate(1, 32'h0040_2004, 2'd3, 0);      // R6 reserved kind
    xlate(1, 32'h0040_3000, 2'd0, 1);      // R4 leaf absent
    xlate(1, 32'h0040_3000, 2'd3, 1);      // R6 presence has priority
    lat_cfg = 2;
    xlate(1, 32'h0040_4321, 2'd1, 0);      // R10 with waits, R7
    xlate(0, 32'h1234_5678, 2'd0, 0);      // R1 with waits
    interfere = 1;
    xlate(1, 32'h0040_5FFF, 2'd0, 0);      // R8 swap mismatch ignored
    interfere = 0;
    lat_cfg = 0;
    pt_base = 32'h0003_0000;
    xlate(1, 32'h0000_0ABC, 2'd2, 1);      // R2 other base, R9

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule